// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a full-duplex serial port with four modes, run by a host through two byte-wide registers. One register holds the control and status byte. The other is the data buffer: a host write to it starts a transmission, and the same location reads back the last byte received.

Mode 0 is a clocked shift register. Data moves on the RXD pin, and a shift clock is driven on TXD, one bit every two clock cycles. Mode 1 sends and receives ten-bit frames: a start bit, eight data bits sent least significant bit first, and a stop bit. Modes 2 and 3 add a ninth data bit between the data and the stop bit. That ninth bit serves multiprocessor addressing: an address byte carries a ninth bit of 1 and wakes the listening stations, while data bytes are filtered out.

Modes 1 and 3 take their bit rate from an external baud-tick input. Mode 2 takes it from the block clock. A double-speed input selects divide-by-16 instead of divide-by-32. The interrupt output is high while either the transmit flag or the receive flag is set.

Top module: `serial_port4`

## Requirements
- R1: The control byte is laid out as [7:6] mode, [5] multiprocessor enable, [4] receive enable, [3] transmit ninth bit, [2] received ninth bit, [1] transmit flag, [0] receive flag. After reset the control byte and the receive buffer read 0, TXD is 1, the RXD driver is off and irq is 0.
- R2: In mode 0, a buffer write leaves TXD high and the RXD driver off for one cycle. The block then drives the 8 data bits on rxd_out, least significant bit first, with rxd_oe high. Each bit lasts two cycles, with TXD low in the first and high in the second. The transmit flag is set in the cycle after the eighth high phase.
- R3: In mode 0, while receive enable is 1 and the receive flag is 0, the block produces 8 shift-clock pulses with the RXD driver off. It samples rxd_in at the end of each high phase, least significant bit first, then loads the receive buffer and sets the receive flag.
- R4: In modes 1 to 3, a transmission starts at a rollover of a free-running divide-by-16 sample counter. The frame is a start bit of 0, the data least significant bit first, the ninth bit in modes 2 and 3, and a stop bit of 1. Every bit lasts 16 sample ticks. The transmit flag is set one bit time after the stop bit begins, and TXD is 1 while idle.
- R5: In modes 1 and 3, a sample tick is every second baud tick, or every baud tick with dbl_speed set. Mode 2 uses every second clock, or every clock with dbl_speed set.
- R6: In modes 2 and 3, the transmit ninth bit (control bit 3, captured at the buffer write) is sent after the data. A received ninth bit is stored in control bit 2.
- R7: In mode 1, the received stop bit is stored in control bit 2.
- R8: In modes 2 and 3 with the multiprocessor enable set, a received frame with a ninth bit of 0 is discarded: the receive flag and the buffer are unchanged. A frame with a ninth bit of 1 is accepted.
- R9: In modes 1 to 3, a falling edge on rxd_in starts reception. Each bit is decided by a majority of the 7th, 8th and 9th sample ticks of that bit, so a single-sample glitch is outvoted. A start bit that votes 1 aborts reception, and the receiver waits for the next falling edge.
- R10: Nothing is received while receive enable is 0. A frame that completes while the receive flag is already set is discarded, and the buffer keeps its old byte.
- R11: Both flags stay set until the host writes them to 0, and irq is the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_ctl | input | 1 | Write strobe for the control byte |
| wr_buf | input | 1 | Write strobe for the data buffer (starts a transmission) |
| wdata | input | 8 | Host write data |
| ctl_q | output | 8 | Control and status byte |
| rbuf_q | output | 8 | Last received byte |
| baud_tick | input | 1 | Rate tick for modes 1 and 3 |
| dbl_speed | input | 1 | Selects divide-by-16 instead of divide-by-32 |
| rxd_in | input | 1 | RXD pin input |
| rxd_out | output | 1 | RXD pin output value in mode 0 |
| rxd_oe | output | 1 | RXD pin output enable (mode 0 transmit) |
| txd | output | 1 | TXD pin: serial data, or the shift clock in mode 0 |
| irq | output | 1 | Interrupt request |

## Verification
The transmit checks follow the TXD line one clock at a time against a frame built in the bench. They are run at three sample-tick rates: the baud tick undivided, the baud tick halved, and the block clock. This separates a wrong bit period or bit order from a wrong ninth bit, and it catches a flag set one cycle early or late. The receive checks use clean frames, frames with a one-sample glitch inside a data bit, and a short low pulse that fakes a start bit. Further frames arrive while the flag is set, while receive enable is off, and with ninth bits of 0 and 1 under multiprocessor filtering. These tell apart the majority vote, the start-bit check and each reason for discarding a byte.

// File: rtl/serial_port4.sv
module serial_port4 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl,
  input  logic       wr_buf,
  input  logic [7:0] wdata,
  output logic [7:0] ctl_q,
  output logic [7:0] rbuf_q,
  input  logic       baud_tick,
  input  logic       dbl_speed,
  input  logic       rxd_in,
  output logic       rxd_out,
  output logic       rxd_oe,
  output logic       txd,
  output logic       irq
);
  logic [1:0] mode;
  logic mpe, ren, tx9, rx9, tflag, rflag;
  logic [7:0] rbuf;
  logic half;
  logic [3:0] tdiv;
  logic tx_pend, tx_act, tx_line;
  logic [3:0] tx_left;
  logic [9:0] tx_sh;
  logic m0_pend, m0_kind, m0_act, m0_tx, m0_ph;
  logic [2:0] m0_cnt;
  logic [7:0] m0_sh;
  logic r_act, r_prev, v0, v1, r_nine;
  logic [3:0] sc, bi;
  logic [7:0] r_sh;

  assign ctl_q  = {mode, mpe, ren, tx9, rx9, tflag, rflag};
  assign rbuf_q = rbuf;
  assign irq    = tflag | rflag;

  wire m0   = (mode == 2'd0);
  wire nine = mode[1];
  wire base = (mode == 2'd2) | (mode[0] & baud_tick);
  wire s16  = base & (dbl_speed | half);
  wire roll = s16 & (tdiv == 4'hf);
  wire maj  = (v0 & v1) | (v0 & rxd_in) | (v1 & rxd_in);
  wire r_ok = !rflag && (!(nine && mpe) || r_nine);

  assign txd     = m0 ? (!m0_act | m0_ph) : tx_line;
  assign rxd_out = m0_sh[0];
  assign rxd_oe  = m0_act & m0_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {mode, mpe, ren, tx9, rx9, tflag, rflag} <= '0;
      rbuf <= '0; half <= 1'b0; tdiv <= '0;
      tx_pend <= 1'b0; tx_act <= 1'b0; tx_line <= 1'b1; tx_left <= '0; tx_sh <= '1;
      m0_pend <= 1'b0; m0_kind <= 1'b0; m0_act <= 1'b0; m0_tx <= 1'b0; m0_ph <= 1'b0;
      m0_cnt <= '0; m0_sh <= '0;
      r_act <= 1'b0; r_prev <= 1'b1; v0 <= 1'b1; v1 <= 1'b1; r_nine <= 1'b0;
      sc <= '0; bi <= '0; r_sh <= '0;
    end else begin
      if (wr_ctl) {mode, mpe, ren, tx9, rx9, tflag, rflag} <= wdata;

      if (base) half <= !half;
      if (s16) tdiv <= tdiv + 4'd1;

      if (wr_buf && m0 && !m0_act && !m0_pend) begin
        m0_pend <= 1'b1; m0_kind <= 1'b1; m0_sh <= wdata;
      end else if (m0 && ren && !rflag && !m0_act && !m0_pend) begin
        m0_pend <= 1'b1; m0_kind <= 1'b0;
      end
      if (m0_pend) begin
        m0_pend <= 1'b0; m0_act <= 1'b1; m0_tx <= m0_kind; m0_ph <= 1'b0; m0_cnt <= '0;
      end else if (m0_act) begin
        m0_ph <= !m0_ph;
        if (m0_ph) begin
          m0_sh  <= {m0_tx ? 1'b1 : rxd_in, m0_sh[7:1]};
          m0_cnt <= m0_cnt + 3'd1;
          if (m0_cnt == 3'd7) begin
            m0_act <= 1'b0;
            if (m0_tx) tflag <= 1'b1;
            else if (!rflag) begin
              rflag <= 1'b1;
              rbuf  <= {rxd_in, m0_sh[7:1]};
            end
          end
        end
      end

      if (wr_buf && !m0 && !tx_act && !tx_pend) begin
        tx_pend <= 1'b1;
        tx_sh   <= nine ? {1'b1, tx9, wdata} : {2'b11, wdata};
        tx_left <= nine ? 4'd10 : 4'd9;
      end
      if (roll) begin
        if (tx_act) begin
          if (tx_left == 4'd0) begin
            tx_act <= 1'b0; tflag <= 1'b1;
          end else begin
            tx_line <= tx_sh[0]; tx_sh <= {1'b1, tx_sh[9:1]}; tx_left <= tx_left - 4'd1;
          end
        end else if (tx_pend) begin
          tx_pend <= 1'b0; tx_act <= 1'b1; tx_line <= 1'b0;
        end
      end

      if (s16) begin
        r_prev <= rxd_in;
        if (!r_act) begin
          if (ren && r_prev && !rxd_in) begin
            r_act <= 1'b1; sc <= '0; bi <= '0;
          end
        end else begin
          sc <= sc + 4'd1;
          if (sc == 4'd6) v0 <= rxd_in;
          if (sc == 4'd7) v1 <= rxd_in;
          if (sc == 4'd8) begin
            bi <= bi + 4'd1;
            if (bi == 4'd0) begin
              if (maj) r_act <= 1'b0;
            end else if (bi <= 4'd8) r_sh <= {maj, r_sh[7:1]};
            else if (nine && bi == 4'd9) r_nine <= maj;
            else begin
              r_act <= 1'b0;
              if (r_ok) begin
                rflag <= 1'b1; rbuf <= r_sh; rx9 <= nine ? r_nine : maj;
              end
            end
          end
        end
      end
    end
  end

  p_rflag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rflag && !wr_ctl) |=> rflag);
  p_tflag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tflag && !wr_ctl) |=> tflag);
  p_full_keeps_buf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rflag |=> $stable(rbuf_q));
  p_m0_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_buf && m0 && !m0_act && !m0_pend) |=> (txd && !rxd_oe));
  p_drive_only_m0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_oe |-> (ctl_q[7:6] == 2'd0));
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!m0 && !tx_act) |-> txd);
  p_addr_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (r_act && s16 && sc == 4'd8 && nine && mpe && bi == 4'd10 && !r_nine && !wr_ctl)
      |=> ($stable(rbuf_q) && rflag == $past(rflag)));
endmodule

// File: tb/tb_serial_port4.sv
module tb_serial_port4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_ctl = 1'b0, wr_buf = 1'b0, baud_tick = 1'b0, dbl_speed = 1'b0, rxd_in = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] ctl_q, rbuf_q;
  logic rxd_out, rxd_oe, txd, irq;
  int vectors = 0, fails = 0, cyc = 0, tcnt = 0, tick_div = 1;

  serial_port4 dut (.clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_buf(wr_buf), .wdata(wdata),
    .ctl_q(ctl_q), .rbuf_q(rbuf_q), .baud_tick(baud_tick), .dbl_speed(dbl_speed),
    .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe), .txd(txd), .irq(irq));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    baud_tick <= ((tcnt % tick_div) == 0);
    tcnt <= tcnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wctl(input logic [7:0] v);
    @(negedge clk); wr_ctl = 1'b1; wdata = v;
    @(negedge clk); wr_ctl = 1'b0;
  endtask

  task automatic wbuf(input logic [7:0] v);
    @(negedge clk); wr_buf = 1'b1; wdata = v;
    @(negedge clk); wr_buf = 1'b0;
  endtask

  function automatic logic [15:0] frame(input logic [7:0] d, input logic nb, input logic b9);
    return nb ? {5'h1f, 1'b1, b9, d, 1'b0} : {6'h3f, 1'b1, d, 1'b0};
  endfunction

  task automatic tx_check(input string req, input logic [15:0] bits, input int n, input int p);
    int w = 0;
    while (txd !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    chk(req, {15'd0, txd}, 16'd0);
    for (int k = 0; k < n * p; k++) begin
      if (txd !== bits[k / p]) chk(req, {15'd0, txd}, {15'd0, bits[k / p]});
      if (k == n * p - 1) chk(req, {15'd0, ctl_q[1]}, 16'd0);
      @(negedge clk);
    end
    vectors = vectors + 1;
    chk(req, {15'd0, ctl_q[1]}, 16'd1);
    chk("R11", {15'd0, irq}, 16'd1);
  endtask

  task automatic rx_drive(input logic [15:0] bits, input int n, input int p, input int g);
    for (int b = 0; b < n; b++)
      for (int k = 0; k < p; k++) begin
        rxd_in = bits[b] ^ ((b == g && k == p / 2) ? 1'b1 : 1'b0);
        @(negedge clk);
      end
    rxd_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  logic [7:0] d0;
  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {8'd0, ctl_q}, 16'd0);
    chk("R1", {8'd0, rbuf_q}, 16'd0);
    chk("R1", {13'd0, txd, rxd_oe, irq}, 16'b100);
    rst_n = 1'b1;

    // R2 mode 0 transmit
    d0 = 8'hA5;
    wbuf(d0);
    chk("R2", {14'd0, txd, rxd_oe}, 16'b10);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R2", {13'd0, txd, rxd_oe, rxd_out}, {13'd0, 1'b0, 1'b1, d0[i]});
      if (i < 7) chk("R2", {15'd0, ctl_q[1]}, 16'd0);
      @(negedge clk);
      chk("R2", {13'd0, txd, rxd_oe, rxd_out}, {13'd0, 1'b1, 1'b1, d0[i]});
    end
    @(negedge clk);
    chk("R2", {13'd0, ctl_q[1], rxd_oe, txd}, 16'b101);
    chk("R11", {15'd0, irq}, 16'd1);
    repeat (5) @(negedge clk);
    chk("R11", {15'd0, ctl_q[1]}, 16'd1);
    wctl(8'h00);
    chk("R11", {15'd0, irq}, 16'd0);

    // R3 mode 0 receive
    d0 = 8'h3C;
    wctl(8'h10);
    for (int i = 0; i < 8; i++) begin
      for (int w = 0; w < 20 && txd !== 1'b0; w++) @(negedge clk);
      rxd_in = d0[i];
      chk("R3", {15'd0, rxd_oe}, 16'd0);
      for (int w = 0; w < 20 && txd !== 1'b1; w++) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk("R3", {15'd0, ctl_q[0]}, 16'd1);
    chk("R3", {8'd0, rbuf_q}, {8'd0, d0});
    rxd_in = 1'b1;
    wctl(8'h00);

    // R4/R5 mode 1, tick every clock, divide by 32
    wctl(8'h40);
    wbuf(8'h5B);
    tx_check("R4", frame(8'h5B, 1'b0, 1'b0), 10, 32);
    wctl(8'h40);
    dbl_speed = 1'b1;
    wbuf(8'h81);
    tx_check("R5", frame(8'h81, 1'b0, 1'b0), 10, 16);
    wctl(8'h40);

    // R7/R9 mode 1 receive with a glitch inside data bit 3
    wctl(8'h50);
    rx_drive(frame(8'h6E, 1'b0, 1'b0), 10, 16, 4);
    chk("R9", {8'd0, rbuf_q}, 16'h006E);
    chk("R7", {13'd0, ctl_q[2], 1'b0, ctl_q[0]}, 16'b101);
    wctl(8'h50);

    // R9 false start bit
    rxd_in = 1'b0; repeat (3) @(negedge clk);
    rxd_in = 1'b1; repeat (40) @(negedge clk);
    chk("R9", {15'd0, ctl_q[0]}, 16'd0);
    rx_drive(frame(8'h11, 1'b0, 1'b0), 10, 16, -1);
    chk("R9", {7'd0, ctl_q[0], rbuf_q}, 16'h0111);

    // R10 flag still set, then receive disabled
    rx_drive(frame(8'h99, 1'b0, 1'b0), 10, 16, -1);
    chk("R10", {8'd0, rbuf_q}, 16'h0011);
    wctl(8'h40);
    rx_drive(frame(8'h77, 1'b0, 1'b0), 10, 16, -1);
    chk("R10", {7'd0, ctl_q[0], rbuf_q}, 16'h0011);

    // R6 mode 2 transmit, ninth bit 1 then 0
    wctl(8'h88);
    wbuf(8'h3C);
    tx_check("R6", frame(8'h3C, 1'b1, 1'b1), 11, 16);
    wctl(8'h80);
    wbuf(8'hC3);
    tx_check("R6", frame(8'hC3, 1'b1, 1'b0), 11, 16);
    wctl(8'h80);

    // R6 mode 2 receive
    wctl(8'h94);
    rx_drive(frame(8'h42, 1'b1, 1'b0), 11, 16, 6);
    chk("R6", {8'd0, rbuf_q}, 16'h0042);
    chk("R6", {14'd0, ctl_q[2], ctl_q[0]}, 16'b01);

    // R8 mode 3 address filter, tick every 2 clocks, doubled
    tick_div = 2;
    wctl(8'hF0);
    rx_drive(frame(8'h55, 1'b1, 1'b0), 11, 32, -1);
    chk("R8", {7'd0, ctl_q[0], rbuf_q}, 16'h0042);
    rx_drive(frame(8'hA7, 1'b1, 1'b1), 11, 32, -1);
    chk("R8", {7'd0, ctl_q[0], rbuf_q}, 16'h01A7);
    chk("R8", {15'd0, ctl_q[2]}, 16'd1);
    chk("R11", {15'd0, irq}, 16'd1);

    // R5 mode 3 transmit
    wctl(8'hC0);
    wbuf(8'h0F);
    tx_check("R5", frame(8'h0F, 1'b1, 1'b0), 11, 32);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule